// File: doc/BRIEF.md
# Sticky Status Register Bank with Selectable Clear

This block holds a row of sticky status flags. A one-cycle pulse on any event line sets the matching flag, and the flag stays set until software clears it. One mode input picks the clear method for every flag at once. With the mode low, a flag clears only when software writes a one to its position. With the mode high, a read returns the flags and clears exactly the flags it returned.

The register-bus side has a read strobe, a write strobe, a select line that is high when the bus address matches this register, and write data. Each cycle, a decoder sorts the strobes into one of three access kinds: ACC_NONE (no selected strobe), ACC_READ (selected read, which wins when both strobes are high) and ACC_WRITE (selected write alone). The kind sets the clear mask for that edge. Read data is registered. It appears one cycle after the read strobe and holds until the next selected read. An interrupt output is the OR of the flags whose mask bits are high.

Top module: `sticky_status_bank`

## Requirements
- R1: While reset is asserted, and directly after it, every flag is 0, rdata is 0 and irq is 0.
- R2: A 1 on evt[i] sets flag i at the next clock edge. The flag then stays set while no clear acts on it.
- R3: With clr_on_rd = 0, a selected write clears each flag i whose wdata[i] is 1 and leaves the other flags unchanged.
- R4: With clr_on_rd = 0, a selected read does not change any flag.
- R5: With clr_on_rd = 1, a selected read puts the flags held before that edge on rdata in the following cycle, and clears those flags at the same edge.
- R6: With clr_on_rd = 1, a selected write (without a read) does not change any flag.
- R7: An event at the same edge as a clear of its flag wins, and the flag stays set.
- R8: irq is 1 exactly when some flag i is 1 with mask[i] = 1. It follows the flags and the mask in the same cycle.
- R9: Strobes with sel = 0 change neither the flags nor rdata.
- R10: A selected cycle with both strobes high is treated as a read only, and wdata is ignored.
- R11: rdata keeps the value of the last selected read until the next selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_on_rd | input | 1 | Clear method: 0 = write one to clear, 1 = clear on read |
| evt | input | W | One-cycle event pulses, one per flag |
| sel | input | 1 | Address match for this register |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | W | Write data (ones select flags to clear) |
| mask | input | W | Interrupt enable per flag |
| rdata | output | W | Registered read data |
| irq | output | 1 | OR of masked flags |

## Verification
A corrupted flag shows up at the next selected read, one cycle after its strobe. It also shows on irq in the same cycle, if the mask bit for that flag is high. A wrong clear mask, such as a write acting in clear-on-read mode or a read clearing in write-one-to-clear mode, shows only when the register is read again. So the bench reads every flag twice in a row, and the second read exposes side effects the first one caused. Event and clear collisions are placed on the same edge, so that a lost event shows as a missing bit on the next read.

// File: rtl/sticky_status_pkg.sv
package sticky_status_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    typedef enum logic {
        CLR_W1C   = 1'b0,
        CLR_ON_RD = 1'b1
    } clr_mode_e;

endpackage

// File: rtl/sticky_access_decode.sv
module sticky_access_decode
    import sticky_status_pkg::*;
(
    input  logic sel,
    input  logic rd_stb,
    input  logic wr_stb,
    output acc_e acc
);

    always_comb begin
        unique case ({sel, rd_stb, wr_stb})
            3'b110, 3'b111: acc = ACC_READ;   // read wins over write
            3'b101:         acc = ACC_WRITE;
            default:        acc = ACC_NONE;
        endcase
    end

endmodule

// File: rtl/sticky_clear_gen.sv
module sticky_clear_gen
    import sticky_status_pkg::*;
#(
    parameter int W = 8
) (
    input  acc_e          acc,
    input  clr_mode_e     mode,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  flags,
    output logic [W-1:0]  clr
);

    always_comb begin
        clr = '0;
        unique case (acc)
            ACC_READ:  if (mode == CLR_ON_RD) clr = flags;
            ACC_WRITE: if (mode == CLR_W1C)   clr = wdata;
            ACC_NONE:  clr = '0;
            default:   clr = '0;
        endcase
    end

endmodule

// File: rtl/sticky_bit.sv
module sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;   // event beats clear
        else if (clr) q <= 1'b0;
    end

endmodule

// File: rtl/sticky_status_bank.sv
module sticky_status_bank
    import sticky_status_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_on_rd,
    input  logic [W-1:0] evt,
    input  logic         sel,
    input  logic         rd_stb,
    input  logic         wr_stb,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] mask,
    output logic [W-1:0] rdata,
    output logic         irq
);

    acc_e         acc;
    clr_mode_e    mode;
    logic [W-1:0] lat_q;
    logic [W-1:0] clr_m;
    logic [W-1:0] rdata_q;

    assign mode = clr_mode_e'(clr_on_rd);

    sticky_access_decode u_dec (
        .sel    (sel),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .acc    (acc)
    );

    sticky_clear_gen #(.W(W)) u_clr (
        .acc   (acc),
        .mode  (mode),
        .wdata (wdata),
        .flags (lat_q),
        .clr   (clr_m)
    );

    for (genvar i = 0; i < W; i++) begin : g_bit
        sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (evt[i]),
            .clr   (clr_m[i]),
            .q     (lat_q[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              rdata_q <= '0;
        else if (acc == ACC_READ) rdata_q <= lat_q;
    end

    assign rdata = rdata_q;
    assign irq   = |(lat_q & mask);

endmodule

// File: rtl/sticky_status_chk.sv
module sticky_status_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_on_rd,
    input logic [W-1:0] evt,
    input logic         sel,
    input logic         rd_stb,
    input logic         wr_stb,
    input logic [W-1:0] wdata,
    input logic [W-1:0] mask,
    input logic [W-1:0] rdata,
    input logic         irq,
    input logic [W-1:0] lat
);

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((lat & $past(evt)) == $past(evt)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (lat == ($past(lat) | $past(evt))) && $stable(rdata));

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_on_rd && sel && wr_stb && !rd_stb)
        |=> lat == (($past(lat) & ~$past(wdata)) | $past(evt)));

    p_rd_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_on_rd && sel && rd_stb)
        |=> (lat == ($past(lat) | $past(evt))) && (rdata == $past(lat)));

    p_cor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_on_rd && sel && rd_stb)
        |=> (rdata == $past(lat)) && (lat == $past(evt)));

    p_wr_ign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_on_rd && sel && wr_stb && !rd_stb)
        |=> lat == ($past(lat) | $past(evt)));

    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((lat & mask) != '0));

    p_noirq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat & mask) != '0) |-> irq);

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && rd_stb) |=> $stable(rdata));

    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (lat == '0 && rdata == '0 && !irq);
        end
    end

endmodule

bind sticky_status_bank sticky_status_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_on_rd (clr_on_rd),
    .evt       (evt),
    .sel       (sel),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .wdata     (wdata),
    .mask      (mask),
    .rdata     (rdata),
    .irq       (irq),
    .lat       (lat_q)
);

// File: tb/sticky_status_bank_tb.sv
module sticky_status_bank_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_on_rd = 1'b0;
    logic [W-1:0] evt = '0;
    logic         sel = 1'b0;
    logic         rd_stb = 1'b0;
    logic         wr_stb = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] mask = '0;
    logic [W-1:0] rdata;
    logic         irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [W-1:0] model = '0;
    logic         cur_mode = 1'b0;
    logic [W-1:0] cur_mask = '0;
    logic [W-1:0] last_rd = '0;
    string        cur_tag = "R8";

    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    bit           pend = 0;

    always #5 clk = ~clk;

    sticky_status_bank #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_on_rd(clr_on_rd), .evt(evt),
        .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata),
        .mask(mask), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one bus cycle; pushes expected read data, advances the model.
    task automatic drive(input logic [W-1:0] e, input logic s, input logic r,
                         input logic w, input logic [W-1:0] d);
        logic [W-1:0] clr;
        @(posedge clk);
        #1;
        check(cur_tag, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, |(model & mask)});
        clr_on_rd = cur_mode; mask = cur_mask;
        evt = e; sel = s; rd_stb = r; wr_stb = w; wdata = d;
        clr = '0;
        if (s && r) begin
            exp_q.push_back(model);
            tag_q.push_back(cur_mode ? "R5" : "R4");
            if (cur_mode) clr = model;
        end else if (s && w && !cur_mode) begin
            clr = d;
        end
        model = (model & ~clr) | e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic rd();
        drive('0, 1'b1, 1'b1, 1'b0, '0);
    endtask

    // Monitor: compares registered read data one cycle after a selected read.
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R11: actual %h expected no read", rdata);
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_rd = e;
                check(t, rdata, e);
            end
        end
        pend = rst_n && sel && rd_stb;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", rdata, '0);
        check("R1", {{(W-1){1'b0}}, irq}, '0);
        rst_n = 1'b1;
        idle(1);
        rd();                                   // R1: flags clear after reset
        idle(1);

        // R2: events latch and persist; R4: read twice without clearing
        drive(8'h05, 1'b0, 1'b0, 1'b0, '0);
        idle(3);
        rd(); rd();
        idle(1);

        // R3: write one to clear only selected bits
        drive('0, 1'b1, 1'b0, 1'b1, 8'h01);
        rd();
        drive('0, 1'b1, 1'b0, 1'b1, 8'hF0);
        rd();
        idle(1);

        // R9: unselected write and read have no effect; R11: rdata holds
        drive('0, 1'b0, 1'b0, 1'b1, 8'hFF);
        drive('0, 1'b0, 1'b1, 1'b0, '0);
        idle(2);
        check("R11", rdata, last_rd);
        rd();
        idle(1);

        // R7: event on same edge as write clear
        drive(8'h04, 1'b1, 1'b0, 1'b1, 8'h04);
        rd();
        idle(1);

        // R6: writes ignored in clear-on-read mode; R5: read clears
        cur_mode = 1'b1;
        drive('0, 1'b1, 1'b0, 1'b1, 8'hFF);
        rd(); rd();
        idle(1);

        // R7/R5: event during clearing read keeps its flag
        drive(8'h40, 1'b0, 1'b0, 1'b0, '0);
        drive(8'h80, 1'b1, 1'b1, 1'b0, '0);
        rd(); rd();
        idle(1);

        // R10: both strobes, clear-on-read mode: read semantics, write ignored
        drive(8'h30, 1'b0, 1'b0, 1'b0, '0);
        drive('0, 1'b1, 1'b1, 1'b1, 8'h00);
        rd();
        // R10: both strobes, write-one-to-clear mode: no clear at all
        cur_mode = 1'b0;
        drive(8'h30, 1'b0, 1'b0, 1'b0, '0);
        drive('0, 1'b1, 1'b1, 1'b1, 8'h30);
        rd();
        idle(1);

        // R8: interrupt follows mask
        cur_tag = "R8";
        cur_mask = 8'h10; idle(2);
        cur_mask = 8'h0C; idle(2);
        drive(8'h08, 1'b0, 1'b0, 1'b0, '0);
        idle(2);
        drive('0, 1'b1, 1'b0, 1'b1, 8'hFF);
        idle(2);
        cur_mask = 8'hFF; idle(2);
        rd();
        idle(3);

        check("R11", rdata, last_rd);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule